// File: doc/BRIEF.md
# Transactional Store Undo Logger

This unit gives one processor eager version management for transactional stores. Stores always update the data memory in place, so new values are visible at once. Before the first store to a block inside a transaction changes that block, the unit reads the block's current contents. It writes the block address and that old value as one entry into a log region, which sits in a separate memory. A per-block "written" flag makes sure that each block is saved only once per transaction.

Commit is purely local. It moves the log pointer back to the base of the region and clears every written flag, all in one cycle. Abort walks the log backwards, from the newest entry to the oldest. It writes each saved value back to its block until the pointer is back at the base.

The log region is bounded by two configuration inputs, a base and a limit. The current pointer is reported on its own port. If a store needs a new entry while the log is full, the unit raises an overflow flag and holds the store. The flag clears when the transaction commits or aborts.

Top module: `undo_log_unit`

## Requirements
- R1: While reset is active and right after it, `log_ptr` equals `cfg_log_base`, and `tx_active`, `rollback_busy`, `log_overflow`, `st_ready`, `mem_we`, `mem_re`, `log_we` and `log_re` are all 0.
- R2: A store presented with no transaction open is written to `mem_addr`/`mem_wdata` in the same cycle, with `st_ready` high. No log write takes place.
- R3: Inside a transaction, the first store to a block runs over three cycles. In the first cycle the unit reads the block (`mem_re`). In the second it writes one log entry at address `log_ptr`, and `log_ptr` then advances by one. In the third it writes the store, with `st_ready` high. The entry format is `{block address, old data}`, with the address in the upper ADDR_W bits and the data in the lower DATA_W bits.
- R4: Further stores to a block that is already logged in the same transaction are written at once, with no added log entry.
- R5: A commit during an open transaction returns `log_ptr` to `cfg_log_base` in one cycle and closes the transaction. It also forgets every logged block, so the next transaction logs those blocks again.
- R6: An abort raises `rollback_busy`. It then restores the logged blocks from the newest entry to the oldest, taking two cycles per entry. `rollback_busy` stays high for 2n+1 cycles for n entries, and at the end memory holds its contents from the start of the transaction and `log_ptr` equals the base.
- R7: While `rollback_busy` is high, `tx_begin` is ignored and stores are held with `st_ready` low.
- R8: A store that needs a log entry while `log_ptr` equals `cfg_log_limit` sets `log_overflow` and is held, with no memory or log write. The flag clears on commit or at the end of a rollback.
- R9: When abort and commit are asserted in the same cycle, the abort wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_log_base | input | LOG_W | First log entry address |
| cfg_log_limit | input | LOG_W | Log address one past the last usable entry |
| tx_begin | input | 1 | Open a transaction (pulse) |
| tx_commit | input | 1 | Commit the open transaction (pulse) |
| tx_abort | input | 1 | Abort the open transaction (pulse) |
| st_valid | input | 1 | Store request, held until accepted |
| st_addr | input | ADDR_W | Store block address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store is written this cycle |
| mem_re | output | 1 | Data memory read strobe, data returns next cycle |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | ADDR_W | Data memory block address |
| mem_wdata | output | DATA_W | Data memory write data |
| mem_rdata | input | DATA_W | Data memory read data |
| log_re | output | 1 | Log memory read strobe, data returns next cycle |
| log_we | output | 1 | Log memory write strobe |
| log_addr | output | LOG_W | Log memory address |
| log_wdata | output | ADDR_W+DATA_W | Log entry written |
| log_rdata | input | ADDR_W+DATA_W | Log entry read |
| tx_active | output | 1 | A transaction is open |
| rollback_busy | output | 1 | Abort restore in progress |
| log_overflow | output | 1 | A store is waiting on a full log |
| log_ptr | output | LOG_W | Current log pointer |

## Verification
The bench repeats stores to a block within one transaction. A unit that ignored the written flag would log a block twice and show a two-cycle latency where none is due. It aborts transactions of several sizes and compares all of memory with a snapshot. Replaying the entries in the wrong order, or stopping one entry short, leaves stale data or gives the wrong busy length. It also shrinks the log so that it fills up, fires `tx_begin` and a store during a rollback, and asserts abort and commit together. A unit that let a store through on a full log, opened a transaction mid-restore, or treated the pair as a commit would each be caught.

// File: rtl/ulog_pkg.sv
package ulog_pkg;
  typedef enum logic [1:0] {
    ULS_RUN   = 2'd0,
    ULS_CAPT  = 2'd1,
    ULS_RB_RD = 2'd2,
    ULS_RB_WR = 2'd3
  } ulog_state_e;
endpackage

// File: rtl/ulog_wbit_table.sv
module ulog_wbit_table #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_idx,
  input  logic              clr_all,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic              rd_bit
);
  localparam int NBLK = 1 << ADDR_W;

  logic [NBLK-1:0] wq;
  logic [NBLK-1:0] wnxt;
  logic            wq_en;

  genvar g;
  generate
    for (g = 0; g < NBLK; g++) begin : g_blk
      assign wnxt[g] = clr_all ? 1'b0
                     : ((set_en && (set_idx == ADDR_W'(g))) ? 1'b1 : wq[g]);
    end
  endgenerate

  assign wq_en = clr_all | set_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wq <= '0;
    else if (wq_en) wq <= wnxt;
  end

  assign rd_bit = wq[rd_idx];

  // R4: a block flagged as logged stays flagged until a clear
  a_r4_flag_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_all) |=> wq[$past(set_idx)]);
  // R5: a clear leaves no block flagged
  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> ($countones(wq) == 0));
endmodule

// File: rtl/ulog_log_ptr.sv
module ulog_log_ptr #(
  parameter int LOG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOG_W-1:0] cfg_base,
  input  logic [LOG_W-1:0] cfg_limit,
  input  logic             inc,
  input  logic             dec,
  input  logic             to_base,
  input  logic             ovf_set,
  input  logic             ovf_clr,
  output logic [LOG_W-1:0] ptr,
  output logic             at_base,
  output logic             at_limit,
  output logic             overflow
);
  logic [LOG_W-1:0] off_q, off_nxt;
  logic             off_en;
  logic             ovf_q, ovf_nxt, ovf_en;

  always_comb begin
    off_en  = inc | dec | to_base;
    off_nxt = off_q;
    if (to_base)  off_nxt = '0;
    else if (dec) off_nxt = off_q - 1'b1;
    else if (inc) off_nxt = off_q + 1'b1;
  end

  always_comb begin
    ovf_en  = ovf_set | ovf_clr;
    ovf_nxt = ovf_set & ~ovf_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (off_en) off_q <= off_nxt;
      if (ovf_en) ovf_q <= ovf_nxt;
    end
  end

  assign ptr      = cfg_base + off_q;
  assign at_base  = (off_q == '0);
  assign at_limit = (ptr == cfg_limit);
  assign overflow = ovf_q;

  // R8: no entry is ever written past the limit
  a_r8_no_inc_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_limit);
  // R6: rollback never walks below the base
  a_r6_no_dec_at_base: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !at_base);
endmodule

// File: rtl/ulog_ctrl.sv
module ulog_ctrl
  import ulog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int LOG_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_begin,
  input  logic                     tx_commit,
  input  logic                     tx_abort,
  input  logic                     st_valid,
  input  logic [ADDR_W-1:0]        st_addr,
  input  logic [DATA_W-1:0]        st_data,
  output logic                     st_ready,
  output logic                     mem_re,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     log_re,
  output logic                     log_we,
  output logic [LOG_W-1:0]         log_addr,
  output logic [ADDR_W+DATA_W-1:0] log_wdata,
  input  logic [ADDR_W+DATA_W-1:0] log_rdata,
  input  logic                     wbit,
  output logic                     wset,
  output logic                     wclr,
  input  logic [LOG_W-1:0]         ptr,
  input  logic                     at_base,
  input  logic                     at_limit,
  output logic                     p_inc,
  output logic                     p_dec,
  output logic                     p_base,
  output logic                     ovf_set,
  output logic                     ovf_clr,
  output logic                     tx_active,
  output logic                     rollback_busy
);
  ulog_state_e state_q, state_nxt;
  logic        act_q, act_nxt;

  always_comb begin
    state_nxt = state_q;
    act_nxt   = act_q;
    st_ready  = 1'b0;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = st_addr;
    mem_wdata = st_data;
    log_re    = 1'b0;
    log_we    = 1'b0;
    log_addr  = ptr;
    log_wdata = {st_addr, mem_rdata};
    wset      = 1'b0;
    wclr      = 1'b0;
    p_inc     = 1'b0;
    p_dec     = 1'b0;
    p_base    = 1'b0;
    ovf_set   = 1'b0;
    ovf_clr   = 1'b0;
    unique case (state_q)
      ULS_RUN: begin
        if (tx_abort && act_q) begin
          state_nxt = ULS_RB_RD;
          act_nxt   = 1'b0;
        end else if (tx_commit && act_q) begin
          p_base  = 1'b1;
          wclr    = 1'b1;
          ovf_clr = 1'b1;
          act_nxt = 1'b0;
        end else begin
          if (tx_begin && !act_q) act_nxt = 1'b1;
          if (st_valid) begin
            if (!act_q || wbit) begin
              mem_we   = 1'b1;
              st_ready = 1'b1;
            end else if (at_limit) begin
              ovf_set = 1'b1;
            end else begin
              mem_re    = 1'b1;
              state_nxt = ULS_CAPT;
            end
          end
        end
      end
      ULS_CAPT: begin
        log_we    = 1'b1;
        wset      = 1'b1;
        p_inc     = 1'b1;
        state_nxt = ULS_RUN;
        if (tx_abort && act_q) begin
          state_nxt = ULS_RB_RD;
          act_nxt   = 1'b0;
        end else if (tx_commit && act_q) begin
          p_base  = 1'b1;
          wclr    = 1'b1;
          ovf_clr = 1'b1;
          act_nxt = 1'b0;
        end
      end
      ULS_RB_RD: begin
        if (at_base) begin
          wclr      = 1'b1;
          ovf_clr   = 1'b1;
          state_nxt = ULS_RUN;
        end else begin
          log_re    = 1'b1;
          log_addr  = ptr - 1'b1;
          state_nxt = ULS_RB_WR;
        end
      end
      ULS_RB_WR: begin
        mem_we    = 1'b1;
        mem_addr  = log_rdata[ADDR_W+DATA_W-1:DATA_W];
        mem_wdata = log_rdata[DATA_W-1:0];
        p_dec     = 1'b1;
        state_nxt = ULS_RB_RD;
      end
      default: state_nxt = ULS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ULS_RUN;
      act_q   <= 1'b0;
    end else begin
      state_q <= state_nxt;
      act_q   <= act_nxt;
    end
  end

  assign tx_active     = act_q;
  assign rollback_busy = (state_q == ULS_RB_RD) || (state_q == ULS_RB_WR);

  // R7: no transaction is open during a restore
  a_r7_busy_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_busy |-> !tx_active);
  // R3: an in-transaction store lands only on an already logged block
  a_r3_store_after_log: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ready && tx_active) |-> wbit);
  // R2: one data memory access per cycle
  a_r2_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re, mem_we}));
  // R6: each restore write retires exactly one entry
  a_r6_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ULS_RB_WR) |=> (ptr == LOG_W'($past(ptr) - 1'b1)));
  // R5: commit returns the pointer to the base
  a_r5_commit_base: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ULS_RUN && act_q && tx_commit && !tx_abort) |=> at_base);
  // R8: a full log blocks the store
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |-> (!st_ready && !log_we));
endmodule

// File: rtl/undo_log_unit.sv
module undo_log_unit #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int LOG_W  = 4,
  localparam int ENT_W = ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  cfg_log_base,
  input  logic [LOG_W-1:0]  cfg_log_limit,
  input  logic              tx_begin,
  input  logic              tx_commit,
  input  logic              tx_abort,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ready,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              log_re,
  output logic              log_we,
  output logic [LOG_W-1:0]  log_addr,
  output logic [ENT_W-1:0]  log_wdata,
  input  logic [ENT_W-1:0]  log_rdata,
  output logic              tx_active,
  output logic              rollback_busy,
  output logic              log_overflow,
  output logic [LOG_W-1:0]  log_ptr
);
  logic wbit, wset, wclr;
  logic at_base, at_limit;
  logic p_inc, p_dec, p_base, ovf_set, ovf_clr;

  ulog_wbit_table #(.ADDR_W(ADDR_W)) u_wbits (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (wset),
    .set_idx (st_addr),
    .clr_all (wclr),
    .rd_idx  (st_addr),
    .rd_bit  (wbit)
  );

  ulog_log_ptr #(.LOG_W(LOG_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_base  (cfg_log_base),
    .cfg_limit (cfg_log_limit),
    .inc       (p_inc),
    .dec       (p_dec),
    .to_base   (p_base),
    .ovf_set   (ovf_set),
    .ovf_clr   (ovf_clr),
    .ptr       (log_ptr),
    .at_base   (at_base),
    .at_limit  (at_limit),
    .overflow  (log_overflow)
  );

  ulog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOG_W(LOG_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_begin      (tx_begin),
    .tx_commit     (tx_commit),
    .tx_abort      (tx_abort),
    .st_valid      (st_valid),
    .st_addr       (st_addr),
    .st_data       (st_data),
    .st_ready      (st_ready),
    .mem_re        (mem_re),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .log_re        (log_re),
    .log_we        (log_we),
    .log_addr      (log_addr),
    .log_wdata     (log_wdata),
    .log_rdata     (log_rdata),
    .wbit          (wbit),
    .wset          (wset),
    .wclr          (wclr),
    .ptr           (log_ptr),
    .at_base       (at_base),
    .at_limit      (at_limit),
    .p_inc         (p_inc),
    .p_dec         (p_dec),
    .p_base        (p_base),
    .ovf_set       (ovf_set),
    .ovf_clr       (ovf_clr),
    .tx_active     (tx_active),
    .rollback_busy (rollback_busy)
  );

  // R1: the unit idles after reset with no requests outstanding
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !rollback_busy && !st_valid) |-> (!mem_we && !mem_re && !log_we && !log_re));
endmodule

// File: tb/undo_log_unit_tb.sv
`timescale 1ns/1ps
module undo_log_unit_tb;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int LW = 4;
  localparam int NB = 1 << AW;
  localparam int NL = 1 << LW;
  localparam logic [LW-1:0] BASE = 4'd2;
  localparam logic [LW-1:0] LIMIT = 4'd14;

  logic clk = 1'b0;
  logic rst_n;
  logic [LW-1:0] cfg_log_base, cfg_log_limit;
  logic tx_begin, tx_commit, tx_abort;
  logic st_valid;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic st_ready, mem_re, mem_we, log_re, log_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [LW-1:0] log_addr, log_ptr;
  logic [AW+DW-1:0] log_wdata, log_rdata;
  logic tx_active, rollback_busy, log_overflow;

  always #2 clk = ~clk;

  undo_log_unit #(.ADDR_W(AW), .DATA_W(DW), .LOG_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_log_base(cfg_log_base), .cfg_log_limit(cfg_log_limit),
    .tx_begin(tx_begin), .tx_commit(tx_commit), .tx_abort(tx_abort),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .log_re(log_re), .log_we(log_we), .log_addr(log_addr),
    .log_wdata(log_wdata), .log_rdata(log_rdata), .tx_active(tx_active),
    .rollback_busy(rollback_busy), .log_overflow(log_overflow), .log_ptr(log_ptr));

  logic [DW-1:0] dmem [NB];
  logic [AW+DW-1:0] lmem [NL];
  logic [DW-1:0] exp_mem [NB];
  logic [DW-1:0] snap [NB];
  bit wflag [NB];
  int n_checks = 0;
  int n_err = 0;
  int log_wr_cnt = 0;

  always @(posedge clk) begin
    if (mem_we) dmem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= dmem[mem_addr];
    if (log_we) lmem[log_addr] <= log_wdata;
    if (log_re) log_rdata <= lmem[log_addr];
  end

  always @(negedge clk) if (log_we) log_wr_cnt++;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  task automatic pulse(input bit b, input bit c, input bit a);
    tx_begin = b; tx_commit = c; tx_abort = a;
    @(posedge clk); #1;
    tx_begin = 0; tx_commit = 0; tx_abort = 0;
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, output int lat);
    st_addr = a; st_data = d; st_valid = 1'b1; lat = 0;
    forever begin
      @(negedge clk);
      if (st_ready || lat > 300) break;
      lat++;
    end
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic tx_store(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit in_tx, inout int n_ent);
    int lat, lw0;
    logic [LW-1:0] p0;
    bit need;
    need = in_tx && !wflag[a];
    p0 = log_ptr;
    lw0 = log_wr_cnt;
    do_store(a, d, lat);
    if (need) begin
      chk("R3", "first-store latency", lat, 2);
      chk("R3", "log entry", lmem[p0], {a, exp_mem[a]});
      chk("R3", "pointer step", log_ptr, LW'(p0 + 1));
      wflag[a] = 1;
      n_ent++;
    end else begin
      chk(req, "direct-store latency", lat, 0);
      chk(req, "no log write", log_wr_cnt - lw0, 0);
    end
    exp_mem[a] = d;
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int i = 0; i < NB; i++) if (dmem[i] !== exp_mem[i]) bad++;
    chk(req, "memory image mismatches", bad, 0);
  endtask

  task automatic open_tx();
    pulse(1, 0, 0);
    for (int i = 0; i < NB; i++) begin snap[i] = exp_mem[i]; wflag[i] = 0; end
  endtask

  task automatic count_busy(output int cnt);
    cnt = 0;
    forever begin
      @(negedge clk);
      if (!rollback_busy || cnt > 300) break;
      cnt++;
    end
    @(posedge clk); #1;
  endtask

  task automatic do_abort(input int n, input bit with_commit);
    int cnt;
    pulse(0, with_commit, 1);
    count_busy(cnt);
    chk("R6", "busy cycles", cnt, 2 * n + 1);
    for (int i = 0; i < NB; i++) exp_mem[i] = snap[i];
    mem_cmp("R6");
    chk("R6", "pointer back at base", log_ptr, cfg_log_base);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat, ne, cnt, lw0;
    bit saw_ready;
    void'($urandom(32'd4242));
    rst_n = 0; cfg_log_base = BASE; cfg_log_limit = LIMIT;
    tx_begin = 0; tx_commit = 0; tx_abort = 0;
    st_valid = 0; st_addr = '0; st_data = '0;
    for (int i = 0; i < NB; i++) begin dmem[i] = DW'(i * 16'h0101 + 16'h0033); exp_mem[i] = dmem[i]; end
    for (int i = 0; i < NL; i++) lmem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ptr in reset", log_ptr, BASE);
    chk("R1", "outputs in reset",
        {tx_active, rollback_busy, log_overflow, st_ready, mem_we, mem_re, log_we, log_re}, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk("R1", "ptr after reset", log_ptr, BASE);
    chk("R1", "flags after reset", {tx_active, rollback_busy, log_overflow}, 0);
    @(posedge clk); #1;

    // R2: store with no transaction
    ne = 0;
    tx_store("R2", 5'd3, 16'hBEEF, 0, ne);
    mem_cmp("R2");

    // R3/R4, then abort together with commit (R9)
    open_tx();
    chk("R3", "tx opened", tx_active, 1);
    ne = 0;
    tx_store("R4", 5'd7, 16'h1111, 1, ne);
    tx_store("R4", 5'd7, 16'h2222, 1, ne);
    tx_store("R4", 5'd9, 16'h3333, 1, ne);
    tx_store("R4", 5'd7, 16'h4444, 1, ne);
    chk("R4", "entries used", log_ptr, BASE + 2);
    do_abort(ne, 1);
    chk("R9", "abort won over commit", tx_active, 0);

    // R7: begin and store issued during rollback
    open_tx(); ne = 0;
    tx_store("R4", 5'd1, 16'hA001, 1, ne);
    tx_store("R4", 5'd2, 16'hA002, 1, ne);
    tx_store("R4", 5'd4, 16'hA004, 1, ne);
    pulse(0, 0, 1);
    for (int i = 0; i < NB; i++) exp_mem[i] = snap[i];
    tx_begin = 1; st_addr = 5'd11; st_data = 16'h5A5A; st_valid = 1;
    @(posedge clk); #1; tx_begin = 0;
    saw_ready = 0; cnt = 0;
    forever begin
      @(negedge clk);
      if (!rollback_busy || cnt > 300) break;
      if (st_ready) saw_ready = 1;
      cnt++;
    end
    chk("R7", "store held while busy", saw_ready, 0);
    chk("R7", "begin ignored during rollback", tx_active, 0);
    chk("R7", "store accepted after rollback", st_ready, 1);
    @(posedge clk); #1; st_valid = 0;
    exp_mem[11] = 16'h5A5A;
    mem_cmp("R7");

    // R5: commit then relog
    open_tx(); ne = 0;
    tx_store("R4", 5'd6, 16'hC006, 1, ne);
    pulse(0, 1, 0);
    @(negedge clk);
    chk("R5", "ptr after commit", log_ptr, BASE);
    chk("R5", "tx closed", tx_active, 0);
    @(posedge clk); #1;
    open_tx(); ne = 0;
    tx_store("R5", 5'd6, 16'hC106, 1, ne);
    chk("R5", "block relogged", ne, 1);
    pulse(0, 1, 0);
    mem_cmp("R5");

    // R8: full log
    cfg_log_limit = BASE + 2;
    open_tx(); ne = 0;
    tx_store("R8", 5'd12, 16'hD012, 1, ne);
    tx_store("R8", 5'd13, 16'hD013, 1, ne);
    lw0 = log_wr_cnt;
    st_addr = 5'd14; st_data = 16'hD014; st_valid = 1;
    repeat (4) @(negedge clk);
    chk("R8", "overflow flag", log_overflow, 1);
    chk("R8", "store held", st_ready, 0);
    chk("R8", "no log write", log_wr_cnt - lw0, 0);
    chk("R8", "ptr at limit", log_ptr, BASE + 2);
    @(posedge clk); #1;
    pulse(0, 0, 1);
    for (int i = 0; i < NB; i++) exp_mem[i] = snap[i];
    count_busy(cnt);
    chk("R8", "overflow cleared by rollback", log_overflow, 0);
    st_valid = 0;
    exp_mem[14] = 16'hD014;
    mem_cmp("R8");
    cfg_log_limit = LIMIT;

    // random transactions
    for (int t = 0; t < 40; t++) begin
      int k;
      if ($urandom % 4 == 0) begin
        ne = 0;
        tx_store("R2", AW'($urandom % 12), DW'($urandom), 0, ne);
      end
      open_tx(); ne = 0;
      k = 1 + $urandom % 8;
      for (int s = 0; s < k; s++)
        tx_store("R4", AW'($urandom % 12), DW'($urandom), 1, ne);
      if ($urandom % 2 == 0) begin
        pulse(0, 1, 0);
        chk("R5", "ptr after random commit", log_ptr, BASE);
        mem_cmp("R5");
      end else begin
        do_abort(ne, 0);
      end
    end

    finish_run();
  end
endmodule